// File: doc/BRIEF.md
# Steered Watchdog Timer

This block supervises software with a countdown that is set up through a single configuration byte. The byte holds a resolution field and a multiplier field. Together they give a timeout in sixteenths of a second, counted on a 16 Hz tick strobe. Software keeps the watchdog from firing by writing the byte again, or simply by reading it back, before the countdown runs out. Either access restarts the count from the full timeout.

When the countdown runs out, the block raises a sticky watchdog flag. The top bit of the configuration byte then chooses one of two actions. The block either asks the system for a reset, or it emits a single interrupt pulse. On the reset path it also clears its own configuration byte, and it tells the neighbouring calendar register to clear its century bit. A zero configuration byte leaves the watchdog disabled.

Top module: `steered_watchdog`

## Requirements
- R1: After reset, `wd_flag`, `rst_req`, `irq_pulse`, `century_clr` and `cfg_q` are all zero, and no countdown runs, so ticks alone never cause an expiry.
- R2: The timeout in ticks is `mult * 4**res`, where res is configuration bits 1:0 and mult is bits 6:2. Expiry happens on the tick that completes that many ticks after the last restart, and not on any earlier tick.
- R3: When the byte that starts a countdown is zero, the watchdog is disabled and never expires, however many ticks arrive.
- R4: A write stores `cfg_wdata` in the byte seen on `cfg_q` in the next cycle. It restarts the countdown from the new value and clears `wd_flag`.
- R5: A read strobe restarts the countdown from the stored byte and clears `wd_flag`. It leaves `cfg_q` unchanged.
- R6: On expiry, `wd_flag` goes to 1 in the cycle after the expiring tick. It stays at 1 until the next write or read.
- R7: If bit 7 of the stored byte is 1 at expiry, `rst_req` and `century_clr` each pulse high for exactly one cycle, together with the flag being set. `cfg_q` becomes zero, and `irq_pulse` stays low.
- R8: If bit 7 of the stored byte is 0 at expiry, `irq_pulse` goes high for exactly one cycle. `rst_req` and `century_clr` stay low, and `cfg_q` keeps its value.
- R9: An expiry is one-shot. No further expiry happens until the next write or read restarts the countdown.
- R10: A nonzero byte whose multiplier field is zero expires on the first tick after the restart.
- R11: A write and a read in the same cycle act as a write. A restart in the same cycle as a tick discards that tick, so the full timeout is counted from the following ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle strobe, sixteen per second |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration write data: bit 7 steer, bits 6:2 mult, bits 1:0 res |
| cfg_rd | input | 1 | Read strobe for the configuration byte, restarts the countdown |
| cfg_q | output | 8 | Stored configuration byte |
| wd_flag | output | 1 | Sticky watchdog expiry flag |
| rst_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| century_clr | output | 1 | One-cycle request to clear the calendar century bit |

## Verification
The bench counts ticks up to the exact expiry tick for several resolution and multiplier pairs, including the largest timeout. A design with an off-by-one count, or with swapped fields, would fire one tick early or late. The bench runs both steering paths and then keeps ticking after each expiry. A design that retriggers, keeps a nonzero byte after a reset request, or emits pulses longer than one cycle would be caught there. It also checks that a read in mid-count postpones the expiry, and that a restart coinciding with a tick discards that tick. It checks a zero multiplier and a zero byte as well; a design that treated these as equivalent would show either a missing first-tick expiry or a spurious one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CFG_W     = 8;
  localparam int RES_W     = 2;
  localparam int MULT_W    = 5;
  localparam int RES_LSB   = 0;
  localparam int MULT_LSB  = RES_LSB + RES_W;
  localparam int STEER_BIT = CFG_W - 1;
  localparam int MAX_RES   = (1 << RES_W) - 1;
  localparam int MAX_MULT  = (1 << MULT_W) - 1;
  localparam int MAX_TICKS = (1 << (2 * MAX_RES)) * MAX_MULT;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  typedef logic [CFG_W-1:0]  cfg_t;
  typedef logic [TICK_W-1:0] ticks_t;

  // Timeout in ticks: multiplier scaled by four to the power of resolution.
  function automatic ticks_t wdg_ticks(cfg_t c);
    logic [RES_W-1:0]  r;
    logic [MULT_W-1:0] m;
    ticks_t            scaled;
    r = c[RES_LSB +: RES_W];
    m = c[MULT_LSB +: MULT_W];
    scaled = ticks_t'(m);
    return scaled << (2 * r);
  endfunction
endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cfg_t wdata,
  input  logic clr,
  output cfg_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (wr)  q <= wdata;
    else if (clr) q <= '0;
  end

  // R4: a write lands in the stored byte one cycle later
  assert_wr_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  ticks_t load_val,
  input  logic   load_arm,
  input  logic   tick,
  output logic   expire
);
  ticks_t cnt_q;
  logic   armed_q;
  logic   last_tick;

  assign last_tick = cnt_q <= ticks_t'(1);
  assign expire    = armed_q && tick && !restart && last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= load_val;
      armed_q <= load_arm;
    end else if (armed_q && tick) begin
      if (last_tick) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ticks_t'(1);
      end
    end
  end

  // R2: a non-final tick takes exactly one off the count and keeps running
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick && !restart && cnt_q > ticks_t'(1))
      |=> (armed_q && cnt_q == $past(cnt_q) - ticks_t'(1)));
  // R9: after an expiry the countdown is idle unless restarted
  assert_one_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed_q);
  // R3: a disabled load never arms
  assert_zero_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !load_arm) |=> !armed_q);
endmodule

// File: rtl/wdg_action.sv
module wdg_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer_rst,
  input  logic restart,
  output logic flag,
  output logic rst_req,
  output logic irq_pulse,
  output logic century_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      rst_req     <= 1'b0;
      irq_pulse   <= 1'b0;
      century_clr <= 1'b0;
    end else begin
      rst_req     <= expire && steer_rst;
      century_clr <= expire && steer_rst;
      irq_pulse   <= expire && !steer_rst;
      if (restart)     flag <= 1'b0;
      else if (expire) flag <= 1'b1;
    end
  end

  // R6: expiry sets the flag on the next edge
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  // R7: the reset request is a single-cycle pulse
  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8: the interrupt is a single-cycle pulse
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R7: the two actions never coincide
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_pulse));
  // R6: any action comes with the flag
  assert_action_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq_pulse) |-> flag);
endmodule

// File: rtl/steered_watchdog.sv
module steered_watchdog
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_16hz,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cfg_rd,
  output logic [CFG_W-1:0] cfg_q,
  output logic             wd_flag,
  output logic             rst_req,
  output logic             irq_pulse,
  output logic             century_clr
);
  logic   restart;
  cfg_t   restart_cfg;
  ticks_t restart_ticks;
  logic   restart_arm;
  logic   expire;
  logic   steer_rst;
  logic   cfg_clr;

  // R11: a write takes precedence over a read in the same cycle
  assign restart       = cfg_wr || cfg_rd;
  assign restart_cfg   = cfg_wr ? cfg_wdata : cfg_q;
  assign restart_ticks = wdg_ticks(restart_cfg);
  assign restart_arm   = restart_cfg != '0;
  assign steer_rst     = cfg_q[STEER_BIT];
  assign cfg_clr       = expire && steer_rst;

  wdg_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .clr   (cfg_clr),
    .q     (cfg_q)
  );

  wdg_countdown u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .load_val (restart_ticks),
    .load_arm (restart_arm),
    .tick     (tick_16hz),
    .expire   (expire)
  );

  wdg_action u_act (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .steer_rst   (steer_rst),
    .restart     (restart),
    .flag        (wd_flag),
    .rst_req     (rst_req),
    .irq_pulse   (irq_pulse),
    .century_clr (century_clr)
  );

  // R7: a reset request leaves the configuration byte cleared
  assert_cfg_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cfg_q == '0);
  // R7: the century clear travels with the reset request
  assert_century_R7: assert property (@(posedge clk) disable iff (!rst_n)
    century_clr == rst_req);
  // R5: a read alone keeps the stored byte
  assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !cfg_wr && !expire) |=> $stable(cfg_q));
endmodule

// File: tb/tb_steered_watchdog.sv
module tb_steered_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16hz = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       cfg_rd = 1'b0;
  logic [7:0] cfg_q;
  logic       wd_flag, rst_req, irq_pulse, century_clr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  steered_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
    .cfg_q(cfg_q), .wd_flag(wd_flag), .rst_req(rst_req),
    .irq_pulse(irq_pulse), .century_clr(century_clr)
  );

  function automatic int exp_ticks(logic [7:0] b);
    int m;
    m = int'(b[6:2]);
    case (b[1:0])
      2'd0: return m;
      2'd1: return m * 4;
      2'd2: return m * 16;
      default: return m * 64;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // outputs packed as {flag, rst_req, irq, century_clr}
  function automatic int outs();
    return {wd_flag, rst_req, irq_pulse, century_clr};
  endfunction

  task automatic do_tick();
    tick_16hz = 1'b1;
    @(negedge clk);
    tick_16hz = 1'b0;
  endtask

  task automatic do_write(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_read();
    cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  // tick n times with no output allowed
  task automatic quiet_ticks(int n, string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      do_tick();
      if (outs() != 0) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    chk(outs() == 0 && cfg_q == 8'h00, "R1 reset outputs", outs(), 0);
    quiet_ticks(20, "R1 no countdown after reset");
  endtask

  task automatic t_irq_path();
    do_write(8'h0D);
    chk(cfg_q == 8'h0D, "R4 stored byte", cfg_q, 8'h0D);
    quiet_ticks(exp_ticks(8'h0D) - 1, "R2 no early expiry res1 mult3");
    do_tick();
    chk(outs() == 4'b1010, "R8 irq expiry outputs", outs(), 4'b1010);
    @(negedge clk);
    chk(outs() == 4'b1000, "R8 irq single cycle, R6 flag sticky", outs(), 4'b1000);
    chk(cfg_q == 8'h0D, "R8 byte kept", cfg_q, 8'h0D);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        do_tick();
        if (outs() != 4'b1000) seen++;
      end
      chk(seen == 0, "R9 no retrigger", seen, 0);
    end
    do_write(8'h0D);
    chk(wd_flag == 1'b0, "R4 write clears flag", wd_flag, 0);
  endtask

  task automatic t_read_restart();
    do_write(8'h08);
    do_tick();
    do_read();
    do_tick();
    chk(outs() == 0, "R5 read postpones expiry", outs(), 0);
    do_tick();
    chk(outs() == 4'b1010, "R5 expiry after read restart", outs(), 4'b1010);
    do_read();
    chk(wd_flag == 1'b0 && cfg_q == 8'h08, "R5 read clears flag keeps byte",
        {wd_flag, cfg_q}, 8'h08);
  endtask

  task automatic t_reset_path();
    do_write(8'h85);
    quiet_ticks(exp_ticks(8'h85) - 1, "R2 no early expiry res1 mult1");
    do_tick();
    chk(outs() == 4'b1101, "R7 reset expiry outputs", outs(), 4'b1101);
    chk(cfg_q == 8'h00, "R7 byte cleared", cfg_q, 0);
    @(negedge clk);
    chk(outs() == 4'b1000, "R7 reset request single cycle", outs(), 4'b1000);
    do_read();
    chk(wd_flag == 1'b0, "R5 read clears flag", wd_flag, 0);
    quiet_ticks(30, "R3 cleared byte stays disabled");
  endtask

  task automatic t_zero();
    do_write(8'h00);
    quiet_ticks(300, "R3 zero byte disabled");
  endtask

  task automatic t_mult0();
    do_write(8'h03);
    do_tick();
    chk(outs() == 4'b1010, "R10 zero multiplier expires on first tick", outs(), 4'b1010);
  endtask

  task automatic t_longest();
    do_write(8'h7F);
    quiet_ticks(exp_ticks(8'h7F) - 1, "R2 no early expiry longest");
    do_tick();
    chk(outs() == 4'b1010, "R2 longest timeout expiry", outs(), 4'b1010);
  endtask

  task automatic t_priority();
    // restart in the same cycle as a tick discards that tick
    cfg_wr = 1'b1; cfg_wdata = 8'h04; tick_16hz = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; tick_16hz = 1'b0;
    chk(outs() == 0, "R11 coincident tick discarded", outs(), 0);
    do_tick();
    chk(outs() == 4'b1010, "R11 expiry on next tick", outs(), 4'b1010);
    // write and read together behave as a write
    cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_wdata = 8'h08;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    chk(cfg_q == 8'h08 && wd_flag == 1'b0, "R11 write wins over read",
        cfg_q, 8'h08);
    do_tick();
    chk(outs() == 0, "R11 new timeout used", outs(), 0);
    do_tick();
    chk(outs() == 4'b1010, "R11 expiry with written value", outs(), 4'b1010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq_path();
    t_read_restart();
    t_reset_path();
    t_zero();
    t_mult0();
    t_longest();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule